// File: doc/BRIEF.md
# Wide-Register CSR Multiplexer

This block is the register front end of a single peripheral register block on a narrow CSR bus. The bus has an address, a read strobe, a write strobe, write data and registered read data. Registers no wider than the bus map straight onto peripheral-side storage. Registers wider than the bus are staged through one read shadow line and one write shadow line, and both lines are shared by every wide register in the block. As a result, software on a narrow bus sees each wide register as a single atomic value.

The default build has a 16-bit bus and three 64-bit registers of four words each. The register map, with each wide register's words at ascending addresses and word i holding bits [16i+15:16i], is:

- Address 0: a control register, read-write.
- Address 1: a status register. Bits [7:0] are read-only peripheral inputs and bits [15:8] are event flags.
- Addresses 2..5: a read-write wide register.
- Addresses 6..9: a read-only wide register.
- Addresses 10..13: a write-only wide register.

Writes to wide registers pass through a two-state sequencer:

- `WS_IDLE`: waits for a write to word 0 of a writable wide register. That write is the *start* transition to `WS_FILL`.
- `WS_FILL`: tracks the target register and the next expected word. The *advance* transition stays in `WS_FILL` and stores the expected word. The *commit* transition returns to `WS_IDLE` when the top word arrives and loads the whole value. The *restart* transition stays in `WS_FILL` on a word-0 write and retargets the sequencer. The *abandon* transition returns to `WS_IDLE` on any other writable-wide write and discards the line.

Top module: `csr_wide_mux`

## Requirements
- R1: After reset the control register, flags, read-write wide register, write-only wide register and read data are all zero.
- R2: A write to address 0 updates `ctrl_q` at that clock edge. A read of address 0 returns it. Read data is loaded at the edge that samples `bus_rd` and holds until the next read.
- R3: Reading address 1 returns `{flag_q, ro_in}`, with the live input in bits [7:0]. Bus writes to bits [7:0] of address 1 have no effect.
- R4: A flag bit is set by a 1 on its `flag_set` bit. It is cleared by writing 1 to bit 8+i of address 1. Writing 0 to that bit leaves the flag unchanged.
- R5: When a set and a clear hit the same flag bit in the same cycle, the flag ends up set.
- R6: Word i of a wide register sits at its base address plus i and carries bits [16i+15:16i].
- R7: Reading word 0 of a readable wide register returns its live word 0 and captures the whole value into the read shadow. Reads of words 1..3 return the captured words, even if the source has since changed.
- R8: Writes to words 0..2 of a writable wide register leave its output unchanged. A write to word 3 in sequence updates all 64 output bits at one clock edge.
- R9: A skipped or repeated word, or a write to the other writable wide register in mid-sequence, abandons the pending line without a commit. A word-0 write always starts a fresh line.
- R10: The read and write shadows are separate. Reading a wide register during a pending write returns the last committed value, and the pending write still commits.
- R11: The write-only wide register reads as zero and commits by the R8 rule. Writes to the read-only wide register are ignored and do not disturb a pending line.
- R12: Addresses 14 and 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (4) | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Registered read data |
| ctrl_q | output | DW (16) | Control register value |
| ro_in | input | DW/2 (8) | Read-only status inputs |
| flag_set | input | DW/2 (8) | Per-bit flag set pulses |
| flag_q | output | DW/2 (8) | Flag values |
| wide_rw_q | output | WW (64) | Read-write wide register |
| wide_ro_in | input | WW (64) | Read-only wide register source |
| wide_wo_q | output | WW (64) | Write-only wide register |

## Verification
Sequential word writes with distinct word values show that the commit is atomic and that each word lands in its own field. Skipped-word, interleaved and restarted sequences separate the abandon path from the restart path. A source that changes between the word-0 read and the later word reads shows whether the upper words come from the shadow or from the live value. Random full-register writes and reads, with random control and status traffic between them, confirm that the shared shadows do not leak data between registers.

// File: rtl/csr_wide_pkg.sv
package csr_wide_pkg;
    typedef enum logic [0:0] {
        WS_IDLE = 1'b0,
        WS_FILL = 1'b1
    } wstate_e;

    typedef enum logic [1:0] {
        WID_RW   = 2'd0,
        WID_RO   = 2'd1,
        WID_WO   = 2'd2,
        WID_NONE = 2'd3
    } wide_id_e;
endpackage

// File: rtl/csr_flag_bank.sv
module csr_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)         q_o[g] <= 1'b0;
            else if (set_i[g])  q_o[g] <= 1'b1;   // set has priority
            else if (clr_i[g])  q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/csr_rshadow.sv
module csr_rshadow #(
    parameter int DW    = 16,
    parameter int WORDS = 4,
    localparam int WW   = DW * WORDS,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [WW-1:0] live_i,
    input  logic [IW-1:0] idx_i,
    output logic [DW-1:0] word_o
);
    logic [WORDS-1:0][DW-1:0] shad_q;
    logic [WORDS-1:0][DW-1:0] live_w;

    assign live_w = live_i;

    always_ff @(posedge clk) begin
        if (!rst_n)      shad_q <= '0;
        else if (load_i) shad_q <= live_w;
    end

    // word 0 comes from the live value, the others from the captured line
    assign word_o = (idx_i == '0) ? live_w[0] : shad_q[idx_i];
endmodule

// File: rtl/csr_wshadow.sv
module csr_wshadow import csr_wide_pkg::*; #(
    parameter int DW    = 16,
    parameter int WORDS = 4,
    localparam int WW   = DW * WORDS,
    localparam int IW   = $clog2(WORDS),
    localparam int LAST = WORDS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  wide_id_e      wr_id_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          commit_o,
    output wide_id_e      commit_id_o,
    output logic [WW-1:0] line_o
);
    wstate_e  st_q, st_d;
    wide_id_e tgt_q, tgt_d;
    logic [IW-1:0] nxt_q, nxt_d;
    logic store;
    logic [LAST*DW-1:0] low_q;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        nxt_d = nxt_q;
        store = 1'b0;
        unique case (st_q)
            WS_IDLE: begin
                if (wr_en_i && wr_idx_i == '0) begin        // start
                    st_d  = WS_FILL;
                    tgt_d = wr_id_i;
                    nxt_d = IW'(1);
                    store = 1'b1;
                end
            end
            WS_FILL: begin
                if (wr_en_i) begin
                    if (wr_id_i == tgt_q && wr_idx_i == nxt_q) begin
                        if (nxt_q == IW'(LAST)) begin       // commit
                            st_d = WS_IDLE;
                        end else begin                      // advance
                            store = 1'b1;
                            nxt_d = nxt_q + IW'(1);
                        end
                    end else if (wr_idx_i == '0) begin      // restart
                        tgt_d = wr_id_i;
                        nxt_d = IW'(1);
                        store = 1'b1;
                    end else begin                          // abandon
                        st_d = WS_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WS_IDLE;
            tgt_q <= WID_NONE;
            nxt_q <= '0;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
            nxt_q <= nxt_d;
        end
    end

    // line storage for all words below the top one
    for (genvar g = 0; g < LAST; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                low_q[g*DW +: DW] <= '0;
            else if (store && wr_idx_i == IW'(g))
                low_q[g*DW +: DW] <= wr_data_i;
        end
    end

    // outputs
    always_comb begin
        commit_o    = (st_q == WS_FILL) && wr_en_i && (wr_id_i == tgt_q)
                      && (wr_idx_i == nxt_q) && (nxt_q == IW'(LAST));
        commit_id_o = tgt_q;
        line_o      = {wr_data_i, low_q};
    end
endmodule

// File: rtl/csr_wide_mux.sv
module csr_wide_mux import csr_wide_pkg::*; #(
    parameter int DW = 16,
    parameter int WW = 64,
    parameter int AW = $clog2(2 + 3 * (WW / DW))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] ctrl_q,
    input  logic [DW/2-1:0] ro_in,
    input  logic [DW/2-1:0] flag_set,
    output logic [DW/2-1:0] flag_q,
    output logic [WW-1:0] wide_rw_q,
    input  logic [WW-1:0] wide_ro_in,
    output logic [WW-1:0] wide_wo_q
);
    localparam int WORDS  = WW / DW;
    localparam int IW     = $clog2(WORDS);
    localparam int HW     = DW / 2;
    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_WIDE = 2;

    logic [AW-1:0] off;
    wide_id_e      wid;
    logic [IW-1:0] widx;
    logic          is_ctrl, is_stat;
    logic [DW-1:0] rs_word, rd_val;
    logic [WW-1:0] live_src;
    logic          ws_commit;
    wide_id_e      ws_id;
    logic [WW-1:0] ws_line;
    logic [HW-1:0] flag_clr;

    // address decode
    always_comb begin
        is_ctrl = (bus_addr == AW'(A_CTRL));
        is_stat = (bus_addr == AW'(A_STAT));
        off     = bus_addr - AW'(A_WIDE);
        widx    = off[IW-1:0];
        if (bus_addr < AW'(A_WIDE))         wid = WID_NONE;
        else if (off < AW'(WORDS))          wid = WID_RW;
        else if (off < AW'(2 * WORDS))      wid = WID_RO;
        else if (off < AW'(3 * WORDS))      wid = WID_WO;
        else                                wid = WID_NONE;
    end

    // narrow control register
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (bus_wr && is_ctrl) ctrl_q <= bus_wdata;
    end

    // flags
    assign flag_clr = (bus_wr && is_stat) ? bus_wdata[DW-1:HW] : '0;

    csr_flag_bank #(.N(HW)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flag_q)
    );

    // read shadow shared by readable wide registers
    assign live_src = (wid == WID_RO) ? wide_ro_in : wide_rw_q;

    csr_rshadow #(.DW(DW), .WORDS(WORDS)) u_rshadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bus_rd && (wid == WID_RW || wid == WID_RO) && widx == '0),
        .live_i (live_src),
        .idx_i  (widx),
        .word_o (rs_word)
    );

    // write shadow shared by writable wide registers
    csr_wshadow #(.DW(DW), .WORDS(WORDS)) u_wshadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (bus_wr && (wid == WID_RW || wid == WID_WO)),
        .wr_id_i     (wid),
        .wr_idx_i    (widx),
        .wr_data_i   (bus_wdata),
        .commit_o    (ws_commit),
        .commit_id_o (ws_id),
        .line_o      (ws_line)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_rw_q <= '0;
            wide_wo_q <= '0;
        end else if (ws_commit) begin
            if (ws_id == WID_RW) wide_rw_q <= ws_line;
            if (ws_id == WID_WO) wide_wo_q <= ws_line;
        end
    end

    // read mux and registered read data
    always_comb begin
        rd_val = '0;
        if (is_ctrl)                            rd_val = ctrl_q;
        else if (is_stat)                       rd_val = {flag_q, ro_in};
        else if (wid == WID_RW || wid == WID_RO) rd_val = rs_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/csr_wide_mux_chk.sv
module csr_wide_mux_chk #(
    parameter int DW = 16,
    parameter int WW = 64,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] ctrl_q,
    input logic [DW/2-1:0] flag_set,
    input logic [DW/2-1:0] flag_q,
    input logic [WW-1:0] wide_rw_q,
    input logic [WW-1:0] wide_wo_q
);
    localparam int WORDS  = WW / DW;
    localparam int HW     = DW / 2;
    localparam int TOP_RW = 2 + WORDS - 1;
    localparam int TOP_WO = 2 + 3 * WORDS - 1;

    logic [HW-1:0] clr_mask;
    assign clr_mask = (bus_wr && bus_addr == AW'(1)) ? bus_wdata[DW-1:HW] : '0;

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(0)) |=> $stable(ctrl_q));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));

    // R4
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flag_q) & ~flag_q) & ~$past(clr_mask)) == '0));

    // R8
    rw_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(TOP_RW)) |=> $stable(wide_rw_q));

    // R11
    wo_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(TOP_WO)) |=> $stable(wide_wo_q));
endmodule

bind csr_wide_mux csr_wide_mux_chk #(.DW(DW), .WW(WW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .flag_set  (flag_set),
    .flag_q    (flag_q),
    .wide_rw_q (wide_rw_q),
    .wide_wo_q (wide_wo_q)
);

// File: tb/csr_wide_mux_test.sv
module csr_wide_mux_test;
    localparam int PERIOD = 10;
    localparam int A_RW = 2;
    localparam int A_RO = 6;
    localparam int A_WO = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] ctrl_q;
    logic [7:0]  ro_in = '0;
    logic [7:0]  flag_set = '0;
    logic [7:0]  flag_q;
    logic [63:0] wide_rw_q;
    logic [63:0] wide_ro_in = '0;
    logic [63:0] wide_wo_q;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    csr_wide_mux uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_q(ctrl_q), .ro_in(ro_in), .flag_set(flag_set), .flag_q(flag_q),
        .wide_rw_q(wide_rw_q), .wide_ro_in(wide_ro_in), .wide_wo_q(wide_wo_q)
    );

    function automatic logic [15:0] word_of(logic [63:0] v, int i);
        return v[i*16 +: 16];
    endfunction

    function automatic logic [63:0] rand64();
        return {$urandom, $urandom};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr_wide(int base, logic [63:0] v);
        for (int i = 0; i < 4; i++) wr(base + i, word_of(v, i));
    endtask

    task automatic rd_wide(string tag, int base, logic [63:0] exp);
        logic [15:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(base + i, d);
            chk(tag, 64'(d), 64'(word_of(exp, i)));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [63:0] va, vb, q1, q2, exp_a, exp_c;
        logic [15:0] exp_ctrl;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", 64'(ctrl_q), 64'h0);
        chk("R1 flags", 64'(flag_q), 64'h0);
        chk("R1 rw", wide_rw_q, 64'h0);
        chk("R1 wo", wide_wo_q, 64'h0);
        chk("R1 rdata", 64'(bus_rdata), 64'h0);

        // R2 narrow read-write
        wr(0, 16'h1234);
        chk("R2 ctrl_q", 64'(ctrl_q), 64'h1234);
        rd(0, d);
        chk("R2 readback", 64'(d), 64'h1234);
        exp_ctrl = 16'h1234;

        // R3 read-only half, writes ignored
        ro_in = 8'h5A;
        rd(1, d);
        chk("R3 status", 64'(d), 64'h005A);
        wr(1, 16'h00FF);
        rd(1, d);
        chk("R3 write ignored", 64'(d), 64'h005A);

        // R4 flag set / clear by one / zero no-op
        @(negedge clk); flag_set = 8'h81;
        @(negedge clk); flag_set = 8'h00;
        chk("R4 set", 64'(flag_q), 64'h81);
        wr(1, 16'h0100);
        chk("R4 clear bit0", 64'(flag_q), 64'h80);
        wr(1, 16'h0000);
        chk("R4 zero no-op", 64'(flag_q), 64'h80);

        // R5 same-cycle set and clear: set wins on bit1, bit7 clears
        @(negedge clk);
        flag_set = 8'h02; bus_addr = 4'd1; bus_wdata = 16'h8200; bus_wr = 1'b1;
        @(negedge clk);
        flag_set = 8'h00; bus_wr = 1'b0;
        chk("R5 set wins", 64'(flag_q), 64'h02);

        // R6 / R8 atomic wide write
        va = 64'h1111_2222_3333_4444;
        for (int i = 0; i < 3; i++) begin
            wr(A_RW + i, word_of(va, i));
            chk("R8 no partial update", wide_rw_q, 64'h0);
        end
        wr(A_RW + 3, word_of(va, 3));
        chk("R8 commit", wide_rw_q, va);
        rd_wide("R6 word layout", A_RW, va);

        // R7 read shadow capture
        q1 = 64'hAAAA_BBBB_CCCC_DDDD;
        q2 = 64'h0102_0304_0506_0708;
        wide_ro_in = q1;
        rd(A_RO, d);
        chk("R7 word0 live", 64'(d), 64'(word_of(q1, 0)));
        wide_ro_in = q2;
        for (int i = 1; i < 4; i++) begin
            rd(A_RO + i, d);
            chk("R7 captured word", 64'(d), 64'(word_of(q1, i)));
        end
        rd(A_RO, d);
        chk("R7 recapture", 64'(d), 64'(word_of(q2, 0)));

        // R10 shadows do not alias
        vb = 64'h5555_6666_7777_8888;
        wr(A_RW + 0, word_of(vb, 0));
        wr(A_RW + 1, word_of(vb, 1));
        rd_wide("R10 read during pending write", A_RW, va);
        wr(A_RW + 2, word_of(vb, 2));
        wr(A_RW + 3, word_of(vb, 3));
        chk("R10 pending write commits", wide_rw_q, vb);
        exp_a = vb;

        // R9 skipped word abandons
        wr(A_RW + 0, 16'hDEAD);
        wr(A_RW + 1, 16'hBEEF);
        wr(A_RW + 3, 16'hF00D);
        chk("R9 skip no commit", wide_rw_q, exp_a);
        wr(A_RW + 2, 16'h1111);
        wr(A_RW + 3, 16'h2222);
        chk("R9 no commit after abandon", wide_rw_q, exp_a);
        // R9 interleaved other wide register
        wr(A_RW + 0, 16'h0A0A);
        wr(A_RW + 1, 16'h0B0B);
        wr(A_WO + 0, 16'h0C0C);
        wr(A_RW + 2, 16'h0D0D);
        wr(A_RW + 3, 16'h0E0E);
        chk("R9 interleave rw", wide_rw_q, exp_a);
        chk("R9 interleave wo", wide_wo_q, 64'h0);
        // R9 restart with word 0
        wr(A_RW + 0, 16'h9999);
        wr(A_RW + 1, 16'h8888);
        wr(A_RW + 0, 16'h4321);
        wr(A_RW + 1, 16'h8765);
        wr(A_RW + 2, 16'hCBA9);
        wr(A_RW + 3, 16'h0FED);
        exp_a = 64'h0FED_CBA9_8765_4321;
        chk("R9 restart commit", wide_rw_q, exp_a);

        // R11 read-only wide writes ignored, no disturbance
        va = 64'h1357_9BDF_2468_ACE0;
        wr(A_RW + 0, word_of(va, 0));
        wr(A_RO + 1, 16'hFFFF);
        wr(A_RW + 1, word_of(va, 1));
        wr(A_RW + 2, word_of(va, 2));
        wr(A_RW + 3, word_of(va, 3));
        chk("R11 ro write no disturb", wide_rw_q, va);
        exp_a = va;
        rd_wide("R11 ro write ignored", A_RO, q2);
        // R11 write-only
        exp_c = 64'hFACE_B00C_CAFE_D00D;
        wr_wide(A_WO, exp_c);
        chk("R11 wo commit", wide_wo_q, exp_c);
        rd_wide("R11 wo reads zero", A_WO, 64'h0);

        // R12 unmapped
        rd(14, d);
        chk("R12 addr14", 64'(d), 64'h0);
        rd(15, d);
        chk("R12 addr15", 64'(d), 64'h0);

        // random traffic
        for (int n = 0; n < 150; n++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: begin
                    exp_a = rand64();
                    wr_wide(A_RW, exp_a);
                    chk("R8 random rw", wide_rw_q, exp_a);
                end
                1: begin
                    exp_c = rand64();
                    wr_wide(A_WO, exp_c);
                    chk("R11 random wo", wide_wo_q, exp_c);
                end
                2: rd_wide("R6 random rw read", A_RW, exp_a);
                3: begin
                    exp_ctrl = 16'($urandom);
                    wr(0, exp_ctrl);
                    rd(0, d);
                    chk("R2 random ctrl", 64'(d), 64'(exp_ctrl));
                end
                default: begin
                    q1 = rand64();
                    wide_ro_in = q1;
                    ro_in = 8'($urandom);
                    rd_wide("R7 random ro read", A_RO, q1);
                    rd(1, d);
                    chk("R3 random status", 64'(d), 64'({flag_q, ro_in}));
                end
            endcase
        end
        chk("R2 ctrl final", 64'(ctrl_q), 64'(exp_ctrl));

        finish_run();
    end
endmodule